// File: doc/BRIEF.md
# SD Block Transfer Host Sequencer

This block is a host-side bus master that moves one 512-byte block through a byte-wide, register-mapped SD card controller. A one-cycle start request supplies a 24-bit block number and a direction. The sequencer first waits for the controller to report that it is idle. It then loads the block number into three byte registers and issues the read or write command. After that it trades data bytes one handshake at a time, and finally waits for the controller to go idle again before it signals completion.

The controller side is a simple strobed register bus. The sequencer drives a 3-bit address, a write strobe, a read strobe and an 8-bit write bus. Read data comes back combinationally in the same cycle as the read strobe. Data for a read leaves on a valid/ready output stream, and data for a write arrives on a valid/ready input stream. Neither stream loses or repeats a byte, and either side may stall for any number of cycles.

Top module: `sd_blk_seq`

## Requirements
- R1: While rst_ni is low (asserted asynchronously, even in the middle of a transfer), reg_wr_o, reg_rd_o, busy_o, done_o, rx_valid_o and tx_ready_o are all 0. After release, the sequencer is idle.
- R2: A start_i pulse while idle makes busy_o read 1 from the next cycle on. No register write happens until a status read (reg_rd_o=1, address 1) has returned exactly 8'h80.
- R3: The block number is written as three single-cycle writes to address 2 (bits 7:0), then address 3 (bits 15:8), then address 4 (bits 23:16). Bit 7 of the byte written to address 4 is always 0.
- R4: The write that follows the address-4 write goes to address 1 and carries 8'h00 for a read or 8'h01 for a write (dir_wr_i=1).
- R5: A read of the data register (address 0, reg_rd_o=1) happens only in the cycle after a status read that returned exactly 8'hE0, and only while the output slot is empty. Each byte read is then held on rx_data_o with rx_valid_o=1 until rx_ready_i=1.
- R6: A write of the data register (address 0, reg_wr_o=1) happens only in the cycle after a status read that returned exactly 8'hA0, and only while tx_valid_i=1. tx_ready_o is 1 in that cycle, and reg_wdata_o equals tx_data_i.
- R7: Each transfer moves exactly 512 data bytes.
- R8: After the last byte, the sequencer polls status until it reads 8'h80. done_o then goes to 1 for exactly one cycle, with busy_o already 0.
- R9: A start_i that arrives while busy_o=1 is ignored. It produces no second command, and the sequencer stays idle after the current transfer ends.
- R10: reg_wr_o and reg_rd_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled only while idle |
| dir_wr_i | input | 1 | 1 = write block, 0 = read block |
| blk_num_i | input | 24 | Block number |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| reg_addr_o | output | 3 | Controller register address |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data, valid in the strobe cycle |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte valid |
| rx_ready_i | input | 1 | Consumer ready |
| tx_data_i | input | 8 | Byte to write |
| tx_valid_i | input | 1 | Write byte valid |
| tx_ready_o | output | 1 | Write byte accepted |

## Verification
If the state register or the byte counter went wrong, the controller model would see it at once. It would show as an access made against a status value that does not allow it, a block-number write out of order, or an extra data access once the block has ended. These are flagged in the cycle they occur. A wrong count shows up at the end of the block, either as a missing done_o pulse or as a byte total other than 512. A stuck or overwritten output slot corrupts the received byte sequence, which the stream compare catches on the affected byte.

// File: rtl/sd_seq_pkg.sv
`timescale 1ns/1ps
package sd_seq_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] REG_DATA = 3'd0;
  localparam logic [REG_AW-1:0] REG_STAT = 3'd1;
  localparam logic [REG_AW-1:0] REG_NUM0 = 3'd2;
  localparam logic [REG_AW-1:0] REG_NUM1 = 3'd3;
  localparam logic [REG_AW-1:0] REG_NUM2 = 3'd4;

  localparam logic [REG_DW-1:0] ST_READY   = 8'h80;
  localparam logic [REG_DW-1:0] ST_RD_BYTE = 8'hE0;
  localparam logic [REG_DW-1:0] ST_WR_SLOT = 8'hA0;

  localparam logic [REG_DW-1:0] CMD_RD = 8'h00;
  localparam logic [REG_DW-1:0] CMD_WR = 8'h01;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WAIT_RDY,
    S_NUM0,
    S_NUM1,
    S_NUM2,
    S_CMD,
    S_POLL,
    S_RD,
    S_WR,
    S_WAIT_END
  } seq_state_e;
endpackage

// File: rtl/sd_seq_xfer_cnt.sv
`timescale 1ns/1ps
module sd_seq_xfer_cnt #(
  parameter int N_BYTES = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CNT_W = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);

  // R7: a byte taken at the final position returns the count to zero
  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && last_o && !clr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/sd_seq_rx_slot.sv
`timescale 1ns/1ps
module sd_seq_rx_slot #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_no_overwrite_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_o);

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/sd_seq_bus_drv.sv
`timescale 1ns/1ps
module sd_seq_bus_drv
  import sd_seq_pkg::*;
#(
  parameter int BLK_W = 24
) (
  input  seq_state_e         state_i,
  input  logic               dir_wr_i,
  input  logic [BLK_W-1:0]   blk_i,
  input  logic [REG_DW-1:0]  tx_data_i,
  output logic [REG_AW-1:0]  addr_o,
  output logic               wr_o,
  output logic               rd_o,
  output logic [REG_DW-1:0]  wdata_o
);
  always_comb begin
    addr_o  = REG_DATA;
    wr_o    = 1'b0;
    rd_o    = 1'b0;
    wdata_o = '0;
    unique case (state_i)
      S_WAIT_RDY, S_POLL, S_WAIT_END: begin
        addr_o = REG_STAT;
        rd_o   = 1'b1;
      end
      S_NUM0: begin
        addr_o  = REG_NUM0;
        wr_o    = 1'b1;
        wdata_o = blk_i[0 +: 8];
      end
      S_NUM1: begin
        addr_o  = REG_NUM1;
        wr_o    = 1'b1;
        wdata_o = blk_i[8 +: 8];
      end
      S_NUM2: begin
        addr_o  = REG_NUM2;
        wr_o    = 1'b1;
        wdata_o = blk_i[16 +: 8];
      end
      S_CMD: begin
        addr_o  = REG_STAT;
        wr_o    = 1'b1;
        wdata_o = dir_wr_i ? CMD_WR : CMD_RD;
      end
      S_RD: begin
        addr_o = REG_DATA;
        rd_o   = 1'b1;
      end
      S_WR: begin
        addr_o  = REG_DATA;
        wr_o    = 1'b1;
        wdata_o = tx_data_i;
      end
      default: ;
    endcase
  end

  always_comb begin
    assert_one_strobe_R10: assert (!(wr_o && rd_o));
    assert_idle_quiet_R1: assert (!((state_i == S_IDLE) && (wr_o || rd_o)));
  end
endmodule

// File: rtl/sd_blk_seq.sv
`timescale 1ns/1ps
module sd_blk_seq
  import sd_seq_pkg::*;
#(
  parameter int BLK_BYTES = 512,
  parameter int BLK_W     = 24
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        dir_wr_i,
  input  logic [23:0] blk_num_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [2:0]  reg_addr_o,
  output logic        reg_wr_o,
  output logic        reg_rd_o,
  output logic [7:0]  reg_wdata_o,
  input  logic [7:0]  reg_rdata_i,
  output logic [7:0]  rx_data_o,
  output logic        rx_valid_o,
  input  logic        rx_ready_i,
  input  logic [7:0]  tx_data_i,
  input  logic        tx_valid_i,
  output logic        tx_ready_o
);
  // top bit of the high block-number byte is not meaningful on the controller
  localparam logic [BLK_W-1:0] BLK_MASK = {1'b0, {(BLK_W-1){1'b1}}};

  seq_state_e       state_q, state_d;
  logic [BLK_W-1:0] blk_q;
  logic             dir_q;
  logic             done_q;
  logic             last_byte;
  logic             accept;

  assign accept = (state_q == S_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:     if (start_i) state_d = S_WAIT_RDY;
      S_WAIT_RDY: if (reg_rdata_i == ST_READY) state_d = S_NUM0;
      S_NUM0:     state_d = S_NUM1;
      S_NUM1:     state_d = S_NUM2;
      S_NUM2:     state_d = S_CMD;
      S_CMD:      state_d = S_POLL;
      S_POLL: begin
        if (dir_q) begin
          if (reg_rdata_i == ST_WR_SLOT && tx_valid_i) state_d = S_WR;
        end else begin
          if (reg_rdata_i == ST_RD_BYTE && !rx_valid_o) state_d = S_RD;
        end
      end
      S_RD, S_WR: state_d = last_byte ? S_WAIT_END : S_POLL;
      S_WAIT_END: if (reg_rdata_i == ST_READY) state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      blk_q   <= '0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == S_WAIT_END) && (reg_rdata_i == ST_READY);
      if (accept) begin
        blk_q <= blk_num_i & BLK_MASK;
        dir_q <= dir_wr_i;
      end
    end
  end

  sd_seq_xfer_cnt #(.N_BYTES(BLK_BYTES)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .inc_i  ((state_q == S_RD) || (state_q == S_WR)),
    .last_o (last_byte)
  );

  sd_seq_rx_slot #(.DW(REG_DW)) i_rx_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (state_q == S_RD),
    .data_i  (reg_rdata_i),
    .ready_i (rx_ready_i),
    .valid_o (rx_valid_o),
    .data_o  (rx_data_o)
  );

  sd_seq_bus_drv #(.BLK_W(BLK_W)) i_bus (
    .state_i   (state_q),
    .dir_wr_i  (dir_q),
    .blk_i     (blk_q),
    .tx_data_i (tx_data_i),
    .addr_o    (reg_addr_o),
    .wr_o      (reg_wr_o),
    .rd_o      (reg_rd_o),
    .wdata_o   (reg_wdata_o)
  );

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign tx_ready_o = (state_q == S_WR);

  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_num_msb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && reg_addr_o == REG_NUM2) |-> !reg_wdata_o[7]);

  assert_cmd_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && reg_addr_o == REG_STAT) |->
      ($past(reg_wr_o && reg_addr_o == REG_NUM2) && reg_wdata_o[7:1] == 7'd0));

  assert_rd_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_o && reg_addr_o == REG_DATA) |->
      $past(reg_rd_o && reg_addr_o == REG_STAT && reg_rdata_i == ST_RD_BYTE && !rx_valid_o));

  assert_wr_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && reg_addr_o == REG_DATA) |->
      (tx_ready_o && tx_valid_i && reg_wdata_o == tx_data_i &&
       $past(reg_rd_o && reg_addr_o == REG_STAT && reg_rdata_i == ST_WR_SLOT)));

  assert_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(reg_rd_o && reg_rdata_i == ST_READY)));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_no_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(blk_q) && $stable(dir_q)));
endmodule

// File: tb/test_sd_blk_seq.sv
`timescale 1ns/1ps
module test_sd_blk_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, dir_wr_i;
  logic [23:0] blk_num_i;
  logic        busy_o, done_o;
  logic [2:0]  reg_addr_o;
  logic        reg_wr_o, reg_rd_o;
  logic [7:0]  reg_wdata_o, reg_rdata_i;
  logic [7:0]  rx_data_o;
  logic        rx_valid_o, rx_ready_i;
  logic [7:0]  tx_data_i;
  logic        tx_valid_i, tx_ready_o;

  always #2.5 clk = ~clk;

  sd_blk_seq i_sd_blk_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .dir_wr_i(dir_wr_i),
    .blk_num_i(blk_num_i), .busy_o(busy_o), .done_o(done_o),
    .reg_addr_o(reg_addr_o), .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o),
    .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
    .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] gen_rd(input logic [23:0] b, input int i);
    return b[7:0] ^ b[15:8] ^ b[23:16] ^ 8'(i * 37) ^ 8'(i >> 8);
  endfunction

  function automatic logic [7:0] gen_wr(input logic [23:0] b, input int i);
    return 8'(i * 13 + 5) ^ b[7:0] ^ {b[15:12], b[19:16]};
  endfunction

  // ---------------- controller model ----------------
  logic [7:0] m_lba0, m_lba1, m_lba2, m_cmd;
  logic [7:0] m_wbuf [512];
  int   m_mode, m_idx, m_dly, m_init, m_seq;
  logic m_ravail, m_wslot, prev_wr;
  logic [2:0] prev_addr;
  int   n_cmds = 0;
  int   v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r8 = 0, v_r10 = 0;
  logic [7:0] m_stat;

  assign m_stat = {(m_mode == 2) ? m_wslot : 1'b1, (m_mode == 1) && m_ravail,
                   m_mode != 0, m_init != 0, 4'h0};
  assign reg_rdata_i = (reg_addr_o == 3'd0) ? gen_rd({m_lba2, m_lba1, m_lba0}, m_idx) :
                       (reg_addr_o == 3'd1) ? m_stat : 8'h00;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 0; m_idx <= 0; m_dly <= 0; m_init <= 20; m_seq <= 0;
      m_ravail <= 1'b0; m_wslot <= 1'b1; prev_wr <= 1'b0; prev_addr <= 3'd0;
    end else begin
      prev_wr <= reg_wr_o; prev_addr <= reg_addr_o;
      if (m_init > 0) m_init <= m_init - 1;
      if (m_dly > 0) m_dly <= m_dly - 1;
      if (m_mode == 1 && !m_ravail && m_dly == 0) m_ravail <= 1'b1;
      if (m_mode == 2 && !m_wslot && m_dly == 0) m_wslot <= 1'b1;
      if (m_mode == 3 && m_dly == 0) m_mode <= 0;
      if (reg_wr_o && prev_wr && prev_addr == reg_addr_o) v_r3 <= v_r3 + 1;
      if (reg_wr_o) begin
        case (reg_addr_o)
          3'd2, 3'd3, 3'd4: begin
            if (m_mode != 0 || m_init != 0) v_r2 <= v_r2 + 1;
            if (m_seq != int'(reg_addr_o) - 2) v_r3 <= v_r3 + 1;
            m_seq <= m_seq + 1;
            if (reg_addr_o == 3'd2) m_lba0 <= reg_wdata_o;
            else if (reg_addr_o == 3'd3) m_lba1 <= reg_wdata_o;
            else m_lba2 <= reg_wdata_o;
          end
          3'd1: begin
            if (m_mode != 0 || m_init != 0) v_r2 <= v_r2 + 1;
            if (m_seq != 3) v_r4 <= v_r4 + 1;
            m_seq <= 0; m_cmd <= reg_wdata_o; n_cmds <= n_cmds + 1;
            if (reg_wdata_o == 8'h00) begin
              m_mode <= 1; m_idx <= 0; m_ravail <= 1'b0; m_dly <= $urandom_range(1, 4);
            end else if (reg_wdata_o == 8'h01) begin
              m_mode <= 2; m_idx <= 0; m_wslot <= 1'b1;
            end else v_r4 <= v_r4 + 1;
          end
          3'd0: begin
            if (m_mode != 2 || !m_wslot) v_r6 <= v_r6 + 1;
            else begin
              m_wbuf[m_idx] <= reg_wdata_o; m_idx <= m_idx + 1; m_wslot <= 1'b0;
              if (m_idx == 511) begin m_mode <= 3; m_dly <= $urandom_range(2, 6); end
              else m_dly <= $urandom_range(1, 4);
            end
          end
          default: v_r3 <= v_r3 + 1;
        endcase
      end
      if (reg_rd_o && reg_addr_o == 3'd0) begin
        if (m_mode != 1 || !m_ravail) v_r5 <= v_r5 + 1;
        else begin
          m_idx <= m_idx + 1; m_ravail <= 1'b0;
          if (m_idx == 511) begin m_mode <= 3; m_dly <= $urandom_range(2, 6); end
          else m_dly <= $urandom_range(1, 4);
        end
      end
    end
  end

  // ---------------- stream endpoints and monitor (negedge) ----------------
  logic [23:0] cur_blk;
  logic [7:0]  rx_got [512];
  int   rx_n = 0, tx_n = 0, n_done = 0;
  bit   tx_en = 0, tx_took = 0, prev_done = 0;

  always @(negedge clk) begin
    rx_ready_i = ($urandom_range(0, 3) != 0);
    if (rst_n && rx_valid_o && rx_ready_i) begin
      if (rx_n < 512) rx_got[rx_n] = rx_data_o;
      rx_n++;
    end
  end

  always @(negedge clk) begin
    if (tx_took) begin tx_valid_i = 1'b0; tx_took = 0; end
    if (tx_en && !tx_valid_i && tx_n < 512 && $urandom_range(0, 2) != 0) begin
      tx_valid_i = 1'b1;
      tx_data_i  = gen_wr(cur_blk, tx_n);
    end
    if (rst_n && tx_valid_i && tx_ready_o) begin tx_n++; tx_took = 1; end
  end

  always @(negedge clk) begin
    if (rst_n && reg_wr_o && reg_rd_o) v_r10++;
    if (rst_n && done_o) begin
      n_done++;
      if (busy_o || m_stat != 8'h80 || prev_done) v_r8++;
    end
    prev_done = done_o;
  end

  task automatic run_xfer(input logic [23:0] b, input bit dir, input bit inject);
    logic [23:0] exp_b;
    int cmds0, done0, cyc, bad;
    exp_b = b & 24'h7FFFFF;
    cur_blk = exp_b; rx_n = 0; tx_n = 0; tx_en = dir;
    cmds0 = n_cmds; done0 = n_done;
    @(negedge clk);
    start_i = 1'b1; blk_num_i = b; dir_wr_i = dir;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
    if (inject) begin
      cyc = 0;
      while (rx_n + tx_n < 100 && cyc < 20000) begin @(negedge clk); cyc++; end
      start_i = 1'b1; blk_num_i = ~b; dir_wr_i = !dir;
      repeat (2) @(negedge clk);
      start_i = 1'b0;
    end
    cyc = 0;
    while (n_done == done0 && cyc < 40000) begin @(negedge clk); cyc++; end
    tx_en = 0;
    chk(n_done == done0 + 1, "R8", "done pulses", n_done - done0, 1);
    chk(v_r8 == 0, "R8", "done timing violations", v_r8, 0);
    chk(v_r2 == 0, "R2", "write before ready violations", v_r2, 0);
    chk({m_lba2, m_lba1, m_lba0} == exp_b, "R3", "block number", {m_lba2, m_lba1, m_lba0}, exp_b);
    chk(v_r3 == 0, "R3", "block byte order/strobe violations", v_r3, 0);
    chk(m_cmd == {7'd0, dir} && v_r4 == 0, "R4", "command byte", m_cmd, dir);
    chk(v_r10 == 0, "R10", "dual strobe", v_r10, 0);
    bad = 0;
    if (dir) begin
      chk(tx_n == 512 && m_idx == 512, "R7", "bytes written", m_idx, 512);
      for (int i = 0; i < 512; i++) if (m_wbuf[i] != gen_wr(exp_b, i)) bad++;
      chk(bad == 0 && v_r6 == 0, "R6", "write data mismatches/violations", bad + v_r6, 0);
    end else begin
      chk(rx_n == 512 && m_idx == 512, "R7", "bytes read", rx_n, 512);
      for (int i = 0; i < 512; i++) if (rx_got[i] != gen_rd(exp_b, i)) bad++;
      chk(bad == 0 && v_r5 == 0, "R5", "read data mismatches/violations", bad + v_r5, 0);
    end
    if (inject) begin
      chk(n_cmds == cmds0 + 1, "R9", "commands issued", n_cmds - cmds0, 1);
      repeat (30) @(negedge clk);
      chk(busy_o == 1'b0 && n_cmds == cmds0 + 1, "R9", "restart after ignored start",
          n_cmds - cmds0, 1);
    end
  endtask

  initial begin
    int cyc;
    void'($urandom(32'h5D1C0DE));
    rst_n = 1'b0; start_i = 1'b0; dir_wr_i = 1'b0; blk_num_i = '0;
    rx_ready_i = 1'b0; tx_valid_i = 1'b0; tx_data_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!reg_wr_o && !reg_rd_o && !busy_o && !done_o && !rx_valid_o && !tx_ready_o,
        "R1", "outputs in reset", {reg_wr_o, reg_rd_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !reg_wr_o && !reg_rd_o, "R1", "idle after release", busy_o, 0);

    run_xfer(24'h000000, 1'b0, 1'b0);  // started while controller still initialising
    run_xfer(24'hFFFFFF, 1'b1, 1'b0);  // top bit of block number dropped
    run_xfer(24'($urandom), 1'b0, 1'b1);
    run_xfer(24'($urandom), 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) run_xfer(24'($urandom), 1'($urandom), 1'b0);

    // R1: asynchronous reset in the middle of a read
    cur_blk = 24'h123456; rx_n = 0;
    @(negedge clk); start_i = 1'b1; blk_num_i = 24'h123456; dir_wr_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
    cyc = 0;
    while (rx_n < 50 && cyc < 20000) begin @(negedge clk); cyc++; end
    rst_n = 1'b0;
    #1;
    chk(!reg_wr_o && !reg_rd_o && !busy_o && !done_o && !rx_valid_o && !tx_ready_o,
        "R1", "outputs under mid-transfer reset", {reg_wr_o, reg_rd_o, busy_o, rx_valid_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_xfer(24'h00A5C3, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog: actual no completion expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule